// File: doc/BRIEF.md
# Burst Slow-Time Clutter Canceller

This block removes stationary and slowly moving clutter from radar returns ahead of a Doppler filter bank. It accepts complex baseband samples, 10-bit in-phase (I) and 10-bit quadrature (Q), at one sample per range cell per pulse period. It stores a complete burst of pulses for every range cell. When the burst is complete, it runs a second-order difference filter down the slow-time sequence of each range cell, on I and Q alike but separately.

The input side has a sample strobe and a burst-start flag. Range cell and pulse indices are counted internally, so pulse boundaries follow from the cell count. The output is a stream of cancelled complex samples. Each sample is tagged with its range cell and its slow-time index. The output order is cell by cell, and within a cell the slow-time index runs upward, ready for an eight-point transform.

Storage is split into two halves that alternate from burst to burst. This lets the next burst be written while the previous one is read out. The range-cell count is a parameter. The full 500-cell configuration is obtained by setting it, and the default is kept smaller.

Top module: `mti_burst_canceller`

## Requirements
- R1: After reset, `outValid` is 0 and stays 0 until a burst has been fully received.
- R2: For every range cell c and n = 0..7, the I output with slow-time index n equals I[c][n] − 2·I[c][n+1] + I[c][n+2], where I[c][p] is the I sample of cell c in pulse p of the burst.
- R3: The Q output follows the same formula using only Q samples, independent of the I values.
- R4: Inputs are two's-complement 10-bit values and outputs are two's-complement 12-bit values, so full-scale alternating inputs (−512/511) give exactly ±2046 with no wrap-around.
- R5: Each burst yields exactly RANGE_CELLS·8 outputs. They are ordered by ascending `outCell`, and within a cell `outIdx` counts 0 to 7.
- R6: No output of a burst appears before the last sample of its tenth pulse (cell RANGE_CELLS−1) has been accepted.
- R7: A new burst may be written back-to-back while the previous burst is read out, and neither burst's results are corrupted.
- R8: A sample with `inBurstStart` = 1 is taken as cell 0 of pulse 0. Any partly received burst is discarded and produces no output.
- R9: Input order within a burst is pulse-major: RANGE_CELLS samples of pulse 0 in ascending cell order, then pulse 1, and so on up to pulse 9. Idle cycles (`inValid` = 0) between samples have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | One input sample (next range cell) is present |
| inBurstStart | input | 1 | This sample is cell 0 of pulse 0 of a new burst |
| inI | input | DATA_W | In-phase sample, two's complement |
| inQ | input | DATA_W | Quadrature sample, two's complement |
| outValid | output | 1 | Cancelled sample is present |
| outI | output | DATA_W+2 | Cancelled in-phase value |
| outQ | output | DATA_W+2 | Cancelled quadrature value |
| outCell | output | clog2(RANGE_CELLS) | Range cell of the output |
| outIdx | output | clog2(BURST_PULSES−2) | Slow-time index of the output, 0..7 |

## Verification
The bench targets the following cases:
- Every cell and slow-time index of a small configuration, checked against the arithmetic formula. A swapped coefficient or a window that leaks across cell boundaries would show up at once.
- Full-scale alternating inputs. A design that kept only 10 or 11 output bits would wrap these to the wrong sign.
- Two bursts written with no gap, which catches a buffer half being overwritten before it is read.
- A partial burst cut short by a new burst start. A design that did not realign would emit stale or shifted pulses, or the wrong number of outputs.
- Inputs driven with idle gaps and then without gaps, which exposes counters that advance on idle cycles.

// File: rtl/mti_pkg.sv
package mti_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic wrEn;
    logic wrBank;
    logic rdEn;
    logic rdBank;
  } mti_strobe_t;
endpackage

// File: rtl/mti_ctrl.sv
module mti_ctrl
  import mti_pkg::*;
#(
  parameter int CELLS  = 128,
  parameter int PULSES = 10,
  localparam int CELL_W  = $clog2(CELLS),
  localparam int PULSE_W = $clog2(PULSES),
  localparam int ADDR_W  = $clog2(CELLS * PULSES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               inBurstStart,
  output mti_strobe_t        st,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [ADDR_W-1:0]  rdAddr,
  output logic [CELL_W-1:0]  rdCell,
  output logic [PULSE_W-1:0] rdPulse
);
  logic [CELL_W-1:0]  wrCell;
  logic [PULSE_W-1:0] wrPulse;
  logic               wrBank;
  logic [CELL_W-1:0]  curCell;
  logic [PULSE_W-1:0] curPulse;
  logic               lastCell, lastPulse, burstDone;
  logic               rdActive, rdBank, rdLast;

  // a burst-start sample realigns both counters
  assign curCell   = inBurstStart ? '0 : wrCell;
  assign curPulse  = inBurstStart ? '0 : wrPulse;
  assign lastCell  = (curCell == CELL_W'(CELLS - 1));
  assign lastPulse = (curPulse == PULSE_W'(PULSES - 1));
  assign burstDone = inValid && lastCell && lastPulse;

  // cell-major layout: the pulses of one cell sit side by side
  assign wrAddr = ADDR_W'(curCell) * ADDR_W'(PULSES) + ADDR_W'(curPulse);
  assign rdAddr = ADDR_W'(rdCell) * ADDR_W'(PULSES) + ADDR_W'(rdPulse);
  assign rdLast = (rdCell == CELL_W'(CELLS - 1)) && (rdPulse == PULSE_W'(PULSES - 1));

  assign st.wrEn   = inValid;
  assign st.wrBank = wrBank;
  assign st.rdEn   = rdActive;
  assign st.rdBank = rdBank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCell  <= '0;
      wrPulse <= '0;
      wrBank  <= 1'b0;
    end else if (inValid) begin
      if (lastCell) begin
        wrCell  <= '0;
        wrPulse <= lastPulse ? '0 : curPulse + 1'b1;
      end else begin
        wrCell  <= curCell + 1'b1;
        wrPulse <= curPulse;
      end
      if (burstDone) wrBank <= ~wrBank;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdActive <= 1'b0;
      rdBank   <= 1'b0;
      rdCell   <= '0;
      rdPulse  <= '0;
    end else if (burstDone) begin
      rdActive <= 1'b1;
      rdBank   <= wrBank;
      rdCell   <= '0;
      rdPulse  <= '0;
    end else if (rdActive) begin
      if (rdLast) rdActive <= 1'b0;
      if (rdPulse == PULSE_W'(PULSES - 1)) begin
        rdPulse <= '0;
        rdCell  <= rdCell + 1'b1;
      end else begin
        rdPulse <= rdPulse + 1'b1;
      end
    end
  end

  // a finished burst may only hand over when the previous readout is done or on its last read
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> (!rdActive || rdLast)); // R7
endmodule

// File: rtl/mti_dp.sv
module mti_dp
  import mti_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int CELLS  = 128,
  parameter int PULSES = 10,
  localparam int OUT_W   = DATA_W + 2,
  localparam int CELL_W  = $clog2(CELLS),
  localparam int PULSE_W = $clog2(PULSES),
  localparam int IDX_W   = $clog2(PULSES - 2),
  localparam int ADDR_W  = $clog2(CELLS * PULSES),
  localparam int DEPTH   = CELLS * PULSES
) (
  input  logic               clk,
  input  logic               rstN,
  input  mti_strobe_t        st,
  input  logic [DATA_W-1:0]  inI,
  input  logic [DATA_W-1:0]  inQ,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic [CELL_W-1:0]  rdCell,
  input  logic [PULSE_W-1:0] rdPulse,
  output logic               outValid,
  output logic [OUT_W-1:0]   outI,
  output logic [OUT_W-1:0]   outQ,
  output logic [CELL_W-1:0]  outCell,
  output logic [IDX_W-1:0]   outIdx
);
  logic                rdValidQ, rdBankQ;
  logic [CELL_W-1:0]   cellQ;
  logic [PULSE_W-1:0]  pulseQ;
  logic [2*DATA_W-1:0] sample;
  logic                emit;

  // two buffer halves, I and Q packed in one word
  for (genvar b = 0; b < 2; b++) begin : bankGen
    logic [2*DATA_W-1:0] mem [DEPTH];
    logic [2*DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (st.wrEn && (st.wrBank == 1'(b))) mem[wrAddr] <= {inI, inQ};
      if (st.rdEn && (st.rdBank == 1'(b))) q <= mem[rdAddr];
    end
  end

  assign sample = rdBankQ ? bankGen[1].q : bankGen[0].q;
  assign emit   = rdValidQ && (pulseQ >= PULSE_W'(2));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValidQ <= 1'b0;
      rdBankQ  <= 1'b0;
      cellQ    <= '0;
      pulseQ   <= '0;
      outValid <= 1'b0;
      outCell  <= '0;
      outIdx   <= '0;
    end else begin
      rdValidQ <= st.rdEn;
      rdBankQ  <= st.rdBank;
      cellQ    <= rdCell;
      pulseQ   <= rdPulse;
      outValid <= emit;
      if (emit) begin
        outCell <= cellQ;
        outIdx  <= IDX_W'(pulseQ - PULSE_W'(2));
      end
    end
  end

  // per-channel three-tap window: +1, -2, +1
  for (genvar ch = 0; ch < 2; ch++) begin : chanGen
    localparam int LSB = (1 - ch) * DATA_W;
    logic signed [DATA_W-1:0] newS, midS, oldS;
    logic signed [OUT_W-1:0]  yNext, yReg;
    assign newS  = sample[LSB +: DATA_W];
    assign yNext = OUT_W'(oldS) - (OUT_W'(midS) <<< 1) + OUT_W'(newS);
    always_ff @(posedge clk) begin
      if (rdValidQ) begin
        oldS <= midS;
        midS <= newS;
      end
      if (emit) yReg <= yNext;
    end
  end

  assign outI = chanGen[0].yReg;
  assign outQ = chanGen[1].yReg;

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outIdx <= IDX_W'(PULSES - 3)) && (outCell <= CELL_W'(CELLS - 1))); // R5
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid) && outIdx != '0)
      |-> (outIdx == $past(outIdx) + 1'b1) && (outCell == $past(outCell))); // R5
  AST_CELL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outIdx == '0 && $past(outValid, 3)
      && $past(outIdx, 3) == IDX_W'(PULSES - 3) && $past(outCell, 3) != CELL_W'(CELLS - 1))
      |-> (outCell == $past(outCell, 3) + 1'b1)); // R5
endmodule

// File: rtl/mti_burst_canceller.sv
module mti_burst_canceller
  import mti_pkg::*;
#(
  parameter int DATA_W       = 10,
  parameter int RANGE_CELLS  = 128,
  parameter int BURST_PULSES = 10
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                inValid,
  input  logic                                inBurstStart,
  input  logic [DATA_W-1:0]                   inI,
  input  logic [DATA_W-1:0]                   inQ,
  output logic                                outValid,
  output logic [DATA_W+1:0]                   outI,
  output logic [DATA_W+1:0]                   outQ,
  output logic [$clog2(RANGE_CELLS)-1:0]      outCell,
  output logic [$clog2(BURST_PULSES-2)-1:0]   outIdx
);
  localparam int CELL_W  = $clog2(RANGE_CELLS);
  localparam int PULSE_W = $clog2(BURST_PULSES);
  localparam int ADDR_W  = $clog2(RANGE_CELLS * BURST_PULSES);

  mti_strobe_t        st;
  logic [ADDR_W-1:0]  wrAddr, rdAddr;
  logic [CELL_W-1:0]  rdCell;
  logic [PULSE_W-1:0] rdPulse;

  mti_ctrl #(.CELLS(RANGE_CELLS), .PULSES(BURST_PULSES)) ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inBurstStart(inBurstStart),
    .st(st), .wrAddr(wrAddr), .rdAddr(rdAddr), .rdCell(rdCell), .rdPulse(rdPulse)
  );

  mti_dp #(.DATA_W(DATA_W), .CELLS(RANGE_CELLS), .PULSES(BURST_PULSES)) dp (
    .clk(clk), .rstN(rstN), .st(st), .inI(inI), .inQ(inQ),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .rdCell(rdCell), .rdPulse(rdPulse),
    .outValid(outValid), .outI(outI), .outQ(outQ), .outCell(outCell), .outIdx(outIdx)
  );
endmodule

// File: tb/tb_mti_burst_canceller.sv
module tb_mti_burst_canceller;
  localparam int W = 10;
  localparam int CELLS = 4;
  localparam int PULSES = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inBurstStart = 1'b0;
  logic [W-1:0] inI = '0;
  logic [W-1:0] inQ = '0;
  logic outValid;
  logic [W+1:0] outI, outQ;
  logic [1:0] outCell;
  logic [2:0] outIdx;

  int checks = 0;
  int fails = 0;
  int earlyOut = 0;
  bit done = 1'b0;

  int qCell[$], qIdx[$], qI[$], qQ[$], qKind[$];
  int smpI[PULSES][CELLS];
  int smpQ[PULSES][CELLS];

  always #5 clk = ~clk;

  mti_burst_canceller #(.DATA_W(W), .RANGE_CELLS(CELLS), .BURST_PULSES(PULSES)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inBurstStart(inBurstStart),
    .inI(inI), .inQ(inQ), .outValid(outValid), .outI(outI), .outQ(outQ),
    .outCell(outCell), .outIdx(outIdx)
  );

  function automatic int genVal(int b, int c, int p, int ch, bit extreme);
    if (extreme) return ((p % 2) == ch) ? -512 : 511;
    return ((b * 97 + c * 41 + p * p * 13 + p * 7 + ch * 211) % 1024) - 512;
  endfunction

  function automatic string kindReq(int k);
    case (k)
      1: return "R4";
      2: return "R8";
      3: return "R7";
      4: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inBurstStart = 1'b0;
    end
  endtask

  // pulse-major stream; expected results queued just before the last sample
  task automatic sendBurst(int b, int nPulses, bit gaps, bit extreme, int kind);
    for (int p = 0; p < nPulses; p++) begin
      for (int c = 0; c < CELLS; c++) begin
        if (gaps && ((c + p) % 3 == 0)) idle(1 + (p % 2));
        smpI[p][c] = genVal(b, c, p, 0, extreme);
        smpQ[p][c] = genVal(b, c, p, 1, extreme);
        if (nPulses == PULSES && p == PULSES - 1 && c == CELLS - 1) begin
          for (int cc = 0; cc < CELLS; cc++)
            for (int n = 0; n < PULSES - 2; n++) begin
              qCell.push_back(cc);
              qIdx.push_back(n);
              qI.push_back(smpI[n][cc] - 2 * smpI[n+1][cc] + smpI[n+2][cc]);
              qQ.push_back(smpQ[n][cc] - 2 * smpQ[n+1][cc] + smpQ[n+2][cc]);
              qKind.push_back(kind);
            end
        end
        @(negedge clk);
        inValid = 1'b1;
        inBurstStart = (p == 0 && c == 0);
        inI = W'(smpI[p][c]);
        inQ = W'(smpQ[p][c]);
      end
    end
  endtask

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (qI.size() == 0) begin
        earlyOut++;
      end else begin
        int eC, eN, eI, eQ, k;
        eC = qCell.pop_front(); eN = qIdx.pop_front();
        eI = qI.pop_front(); eQ = qQ.pop_front(); k = qKind.pop_front();
        checks += 3;
        if ($signed(outI) != eI) begin
          fails++;
          $display("FAIL %s I cell %0d idx %0d: got %0d expected %0d", kindReq(k), eC, eN, $signed(outI), eI);
        end
        if ($signed(outQ) != eQ) begin
          fails++;
          $display("FAIL R3 Q cell %0d idx %0d: got %0d expected %0d", eC, eN, $signed(outQ), eQ);
        end
        if (int'(outCell) != eC || int'(outIdx) != eN) begin
          fails++;
          $display("FAIL R5 tag: got cell %0d idx %0d expected cell %0d idx %0d", outCell, outIdx, eC, eN);
        end
      end
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      fails++;
      $display("FAIL R1 outValid during reset: got %b expected 0", outValid);
    end
    rstN = 1'b1;
    idle(4);
    checks++;
    if (outValid !== 1'b0) begin
      fails++;
      $display("FAIL R1 outValid after reset: got %b expected 0", outValid);
    end
    // R9: gapped input, then R2/R3 values
    sendBurst(0, PULSES, 1'b1, 1'b0, 4);
    idle(60);
    // R7: two bursts back to back
    sendBurst(1, PULSES, 1'b0, 1'b0, 3);
    sendBurst(2, PULSES, 1'b0, 1'b0, 3);
    idle(60);
    // R4: full-scale alternation
    sendBurst(3, PULSES, 1'b0, 1'b1, 1);
    idle(60);
    // R8: partial burst abandoned by a new burst start
    sendBurst(4, 3, 1'b0, 1'b0, 2);
    idle(2);
    sendBurst(5, PULSES, 1'b1, 1'b0, 2);
    idle(60);
    // plain patterns for R2
    sendBurst(6, PULSES, 1'b0, 1'b0, 0);
    idle(60);
    checks++;
    if (earlyOut != 0) begin
      fails++;
      $display("FAIL R6 outputs without a completed burst: got %0d expected 0", earlyOut);
    end
    checks++;
    if (qI.size() != 0) begin
      fails++;
      $display("FAIL R5 missing outputs: got %0d pending expected 0", qI.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule